// File: doc/BRIEF.md
# Serializer/Deserializer Datapath with Test Loopbacks

This block is the digital core of a byte-wide transmit serializer paired with a byte-wide receive deserializer. All logic runs on one fast clock. The bit clocks of the analogue parts are modelled as single-cycle enables: one from the local transmit synthesizer, one from the receive clock recovery, and one standing for the rising edge of an externally supplied receive clock.

On the transmit side a byte is captured once every `DW` transmit bit enables and shifted out most significant bit first. On the receive side a selected serial source is gathered into bytes. Five level controls rearrange the path:

- **Facility loopback** sends the line input back out of the serial transmit output.
- **Equipment loopback** feeds the serializer straight into the deserializer on the transmit bit timing.
- **Recovery-input loopback** puts the serializer bit in front of the clock-recovery stage in place of the line.
- **Recovery bypass** samples the line on the external receive clock.
- **Loop timing** runs the transmitter from the receive line clock.

A control change never splits a byte. Transmit-side controls are taken at a transmit byte load. Receive-side controls are taken when a received byte completes.

Top module: `serdes_loopback_path`

## Requirements
- R1: On a cycle where `tx_byte_strobe` is high, `tx_par` is captured at that clock edge. Its bits then appear on `tx_ser_out` MSB first, one per transmit bit enable, starting in the cycle after the capture edge.
- R2: `tx_byte_strobe` is high for exactly one cycle in every `DW` transmit bit enables and never in two consecutive cycles. With loop timing off and `tx_local_ce` low, no strobe occurs and `tx_ser_out` holds its value.
- R3: With facility loopback in force, `tx_ser_out` equals the line bit captured at the last line clock enable, and `tx_par` has no effect on it.
- R4: Under facility loopback the line input is still deserialized onto `rx_par`.
- R5: With equipment loopback in force, the deserializer takes the serializer bit on every transmit bit enable, in place of the line.
- R6: Under equipment loopback, `tx_ser_out` still carries the serialized `tx_par` bytes.
- R7: With recovery-input loopback in force (and equipment loopback off), the deserializer takes the serializer bit on the recovered clock enable `rx_rec_ce`.
- R8: With recovery bypass in force, the deserializer samples `line_in` on `rx_ext_ce`, and `rx_rec_ce` has no effect. The line clock used by facility loopback and loop timing is then also `rx_ext_ce`.
- R9: With loop timing in force, the transmitter advances on the receive line clock enable, and `tx_local_ce` has no effect.
- R10: With facility and equipment loopback both in force, `rx_par` carries the serialized `tx_par` data and `tx_ser_out` carries the line data.
- R11: Facility loopback and loop timing are taken at the edge where a byte is loaded and apply from that byte on. Equipment loopback, recovery-input loopback and bypass are taken at the edge that completes a received byte and apply from the next sampled bit on.
- R12: After each `DW` receive samples, `rx_par` shows the last `DW` sampled bits with the earliest in the MSB, and `rx_par_vld` pulses for one cycle. In reset, `tx_ser_out`, `rx_par` and `rx_par_vld` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared by all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_local_ce | input | 1 | Transmit bit enable from the local synthesizer |
| rx_rec_ce | input | 1 | Bit enable from receive clock recovery |
| rx_ext_ce | input | 1 | Rising-edge enable of the external receive clock |
| line_in | input | 1 | Serial line data |
| tx_par | input | DW | Parallel transmit byte |
| fac_lb_en | input | 1 | Facility loopback request |
| equ_lb_en | input | 1 | Equipment loopback request |
| cru_lb_en | input | 1 | Loopback ahead of clock recovery request |
| cru_byp_en | input | 1 | Clock recovery bypass request |
| loop_time_en | input | 1 | Loop timing request |
| tx_ser_out | output | 1 | Serial transmit bit |
| tx_byte_strobe | output | 1 | Byte strobe for the upstream transmit source |
| rx_par | output | DW | Parallel receive byte |
| rx_par_vld | output | 1 | Pulse when `rx_par` is updated |

## Verification
The bench builds the block with `DW = 8`, the width of a byte-wide line interface.

At that width the bench can drive enable patterns by hand and get the effects it needs:
- A full-rate enable on one clock and a half-rate enable on the other makes a wrong clock choice corrupt whole bytes.
- Mode changes can be placed a few bits into a byte, which reaches both kinds of byte-boundary latching.
- Loop timing combined with a silenced local enable shows that the transmitter follows the receive line clock.

// File: rtl/serdes_lb_pkg.sv
package serdes_lb_pkg;

  // Transmit-side controls, taken at a byte load.
  typedef struct packed {
    logic fac;      // facility loopback
    logic loop_tm;  // loop timing
  } tx_mode_t;

  // Receive-side controls, taken when a received byte completes.
  typedef struct packed {
    logic equ;      // equipment loopback
    logic cru_lp;   // loopback ahead of clock recovery
    logic byp;      // clock recovery bypass
  } rx_mode_t;

  // Clock of the incoming line: external when recovery is bypassed.
  function automatic logic pick_line_ce(rx_mode_t m, logic rec_ce, logic ext_ce);
    return m.byp ? ext_ce : rec_ce;
  endfunction

  // Transmit bit timing: receive line clock in loop timing.
  function automatic logic pick_tx_ce(tx_mode_t m, logic local_ce, logic line_ce);
    return m.loop_tm ? line_ce : local_ce;
  endfunction

  // Deserializer bit timing. Equipment loopback rides the transmit timing;
  // otherwise the line clock choice applies.
  function automatic logic pick_rx_ce(rx_mode_t m, logic tx_ce, logic rec_ce, logic ext_ce);
    logic ce;
    if (m.equ) ce = tx_ce;
    else       ce = pick_line_ce(m, rec_ce, ext_ce);
    return ce;
  endfunction

  // Deserializer data. Both internal loopbacks take the serializer bit.
  function automatic logic pick_rx_bit(rx_mode_t m, logic ser_bit, logic line_bit);
    return (m.equ || m.cru_lp) ? ser_bit : line_bit;
  endfunction

endpackage

// File: rtl/lb_mode_hold.sv
module lb_mode_hold #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= din;
  end

  assign dout = q;

endmodule

// File: rtl/lb_serializer.sv
module lb_serializer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_ce,
  input  logic [DW-1:0] par_in,
  output logic          load,
  output logic          ser_bit
);

  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  function automatic logic [CW-1:0] step_count(logic [CW-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic          sbit;

  assign load = bit_ce && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
      sbit  <= 1'b0;
    end else if (bit_ce) begin
      cnt <= step_count(cnt);
      if (load) begin
        shreg <= {par_in[DW-2:0], 1'b0};
        sbit  <= par_in[DW-1];
      end else begin
        shreg <= {shreg[DW-2:0], 1'b0};
        sbit  <= shreg[DW-1];
      end
    end
  end

  assign ser_bit = sbit;

endmodule

// File: rtl/lb_deserializer.sv
module lb_deserializer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_ce,
  input  logic          bit_in,
  output logic          boundary,
  output logic [DW-1:0] par_out,
  output logic          par_vld
);

  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam int AW = DW - 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  function automatic logic [CW-1:0] step_count(logic [CW-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  logic [CW-1:0] cnt;
  logic [AW-1:0] acc;
  logic [DW-1:0] acc_nxt;
  logic [DW-1:0] byte_q;
  logic          vld_q;

  assign acc_nxt  = {acc, bit_in};
  assign boundary = bit_ce && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc    <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= boundary;
      if (bit_ce) begin
        cnt <= step_count(cnt);
        acc <= acc_nxt[AW-1:0];
      end
      if (boundary) byte_q <= acc_nxt;
    end
  end

  assign par_out = byte_q;
  assign par_vld = vld_q;

endmodule

// File: rtl/serdes_loopback_path.sv
module serdes_loopback_path
  import serdes_lb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_local_ce,
  input  logic          rx_rec_ce,
  input  logic          rx_ext_ce,
  input  logic          line_in,
  input  logic [DW-1:0] tx_par,
  input  logic          fac_lb_en,
  input  logic          equ_lb_en,
  input  logic          cru_lb_en,
  input  logic          cru_byp_en,
  input  logic          loop_time_en,
  output logic          tx_ser_out,
  output logic          tx_byte_strobe,
  output logic [DW-1:0] rx_par,
  output logic          rx_par_vld
);

  localparam int TXM_W = $bits(tx_mode_t);
  localparam int RXM_W = $bits(rx_mode_t);

  // Named internal events, also observed by the bound checker.
  tx_mode_t tx_mode_q;
  rx_mode_t rx_mode_q;
  tx_mode_t tx_mode_req;
  rx_mode_t rx_mode_req;
  logic     line_ce;
  logic     tx_ce;
  logic     rx_ce;
  logic     rx_bit;
  logic     rx_bound;
  logic     ser_bit;
  logic     tx_load;
  logic     fac_q;

  assign tx_mode_req = '{fac: fac_lb_en, loop_tm: loop_time_en};
  assign rx_mode_req = '{equ: equ_lb_en, cru_lp: cru_lb_en, byp: cru_byp_en};

  assign line_ce = pick_line_ce(rx_mode_q, rx_rec_ce, rx_ext_ce);
  assign tx_ce   = pick_tx_ce(tx_mode_q, tx_local_ce, line_ce);
  assign rx_ce   = pick_rx_ce(rx_mode_q, tx_ce, rx_rec_ce, rx_ext_ce);
  assign rx_bit  = pick_rx_bit(rx_mode_q, ser_bit, line_in);

  lb_mode_hold #(.W(TXM_W)) u_tx_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (tx_load),
    .din  (tx_mode_req),
    .dout (tx_mode_q)
  );

  lb_mode_hold #(.W(RXM_W)) u_rx_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (rx_bound),
    .din  (rx_mode_req),
    .dout (rx_mode_q)
  );

  lb_serializer #(.DW(DW)) u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_ce (tx_ce),
    .par_in (tx_par),
    .load   (tx_load),
    .ser_bit(ser_bit)
  );

  // Line bit retimed on the line clock for facility loopback.
  always_ff @(posedge clk) begin
    if (!rst_n)       fac_q <= 1'b0;
    else if (line_ce) fac_q <= line_in;
  end

  assign tx_ser_out     = tx_mode_q.fac ? fac_q : ser_bit;
  assign tx_byte_strobe = tx_load;

  lb_deserializer #(.DW(DW)) u_des (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_ce  (rx_ce),
    .bit_in  (rx_bit),
    .boundary(rx_bound),
    .par_out (rx_par),
    .par_vld (rx_par_vld)
  );

endmodule

// File: rtl/serdes_loopback_path_chk.sv
module serdes_loopback_path_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_byte_strobe,
  input logic       rx_par_vld,
  input logic       rx_bound,
  input logic [1:0] tx_mode_bits,
  input logic [2:0] rx_mode_bits,
  input logic       line_ce,
  input logic       line_in,
  input logic       tx_ce,
  input logic       rx_ce,
  input logic       tx_ser_out
);

  // R2
  a_r2_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tx_byte_strobe |=> !tx_byte_strobe);

  // R12
  a_r12_vld_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rx_par_vld |=> !rx_par_vld);

  // R11: transmit controls move only at a byte load
  a_r11_tx_mode_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_mode_bits) |-> $past(tx_byte_strobe));

  // R11: receive controls move only when a byte completes
  a_r11_rx_mode_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_mode_bits) |-> $past(rx_bound));

  // R3: facility loopback output is the line bit one line clock later
  a_r3_fac_retime: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode_bits[1] && $past(tx_mode_bits[1]) && $past(line_ce))
      |-> (tx_ser_out == $past(line_in)));

  // R5: equipment loopback clocks the receiver on transmit timing
  a_r5_equ_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode_bits[2] |-> (rx_ce == tx_ce));

  // R9: loop timing clocks the transmitter from the line clock
  a_r9_loop_clock: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode_bits[0] |-> (tx_ce == line_ce));

endmodule

bind serdes_loopback_path serdes_loopback_path_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_byte_strobe(tx_byte_strobe),
  .rx_par_vld    (rx_par_vld),
  .rx_bound      (rx_bound),
  .tx_mode_bits  (tx_mode_q),
  .rx_mode_bits  (rx_mode_q),
  .line_ce       (line_ce),
  .line_in       (line_in),
  .tx_ce         (tx_ce),
  .rx_ce         (rx_ce),
  .tx_ser_out    (tx_ser_out)
);

// File: tb/serdes_loopback_path_test.sv
module serdes_loopback_path_test;

  localparam int DW         = 8;
  localparam int CLK_PERIOD = 10;
  localparam int HN         = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          tx_local_ce = 1'b1;
  logic          rx_rec_ce = 1'b1;
  logic          rx_ext_ce = 1'b1;
  logic          line_in = 1'b0;
  logic [DW-1:0] tx_par = '0;
  logic          fac_lb_en = 1'b0;
  logic          equ_lb_en = 1'b0;
  logic          cru_lb_en = 1'b0;
  logic          cru_byp_en = 1'b0;
  logic          loop_time_en = 1'b0;
  logic          tx_ser_out;
  logic          tx_byte_strobe;
  logic [DW-1:0] rx_par;
  logic          rx_par_vld;

  serdes_loopback_path #(.DW(DW)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_local_ce   (tx_local_ce),
    .rx_rec_ce     (rx_rec_ce),
    .rx_ext_ce     (rx_ext_ce),
    .line_in       (line_in),
    .tx_par        (tx_par),
    .fac_lb_en     (fac_lb_en),
    .equ_lb_en     (equ_lb_en),
    .cru_lb_en     (cru_lb_en),
    .cru_byp_en    (cru_byp_en),
    .loop_time_en  (loop_time_en),
    .tx_ser_out    (tx_ser_out),
    .tx_byte_strobe(tx_byte_strobe),
    .rx_par        (rx_par),
    .rx_par_vld    (rx_par_vld)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench model state
  bit         pser [HN];   // expected serializer bit seen at each negedge
  bit         smp  [HN];   // bits the receiver is expected to sample
  int         sc = 0;
  int         nidx = 0;
  logic [1:0] tx_pred = '0;  // {fac, loop} in force
  logic [1:0] tx_pend = '0;
  bit         tx_pend_v = 1'b0;
  logic [2:0] rx_pred = '0;  // {equ, cru, byp} in force
  logic [2:0] snap = '0;
  bit         fac_exp = 1'b0;
  bit         load_seen = 1'b0;
  int         load_cnt = 0;
  int         bi = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit         phase = 1'b0;
  bit         rec_alt = 1'b0;
  bit         ext_alt = 1'b0;
  bit         v_tx_local = 1'b1;
  bit         chk_tx = 1'b0;
  bit         chk_rx = 1'b0;
  string      tx_tag = "R1";
  string      rx_tag = "R12";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] gen_byte(int i);
    return DW'((i * 29 + 83) ^ (i >> 3));
  endfunction

  // Per-cycle monitor and driver
  initial begin
    forever begin
      @(negedge clk);
      if (done) break;
      nidx++;
      // +0: check outputs settled after the last edge
      if (tx_pend_v) begin
        tx_pred   = tx_pend;
        tx_pend_v = 1'b0;
      end
      if (rst_n && rx_par_vld) begin
        if (chk_rx && sc >= DW) begin
          logic [DW-1:0] e;
          e = '0;
          for (int k = 0; k < DW; k++) e = {e[DW-2:0], smp[sc-DW+k]};
          chk(rx_par == e, rx_tag, "rx byte", int'(rx_par), int'(e));
        end
        rx_pred = snap;
      end
      if (rst_n && chk_tx && nidx < HN) begin
        bit e1;
        e1 = tx_pred[1] ? fac_exp : pser[nidx];
        chk(tx_ser_out == e1, tx_tag, "tx serial bit", int'(tx_ser_out), int'(e1));
      end
      // +0: drive line and clock enables
      phase       = ~phase;
      lfsr        = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      line_in     = lfsr[0];
      rx_rec_ce   = rec_alt ? phase : 1'b1;
      rx_ext_ce   = ext_alt ? phase : 1'b1;
      tx_local_ce = v_tx_local;
      // +2: supply a byte on the strobe
      #2;
      load_seen = 1'b0;
      if (rst_n && tx_byte_strobe) begin
        load_seen = 1'b1;
        tx_par = gen_byte(bi);
        bi++;
        load_cnt++;
        for (int k = 0; k < DW; k++)
          if (nidx + 1 + k < HN) pser[nidx+1+k] = tx_par[DW-1-k];
      end
      // +4: snapshot controls and predict the coming edge
      #2;
      snap = {equ_lb_en, cru_lb_en, cru_byp_en};
      if (load_seen) begin
        tx_pend   = {fac_lb_en, loop_time_en};
        tx_pend_v = 1'b1;
      end
      if (rst_n && nidx < HN) begin
        bit lce, tce, rce, src;
        lce = rx_pred[0] ? rx_ext_ce : rx_rec_ce;
        tce = tx_pred[0] ? lce : tx_local_ce;
        rce = rx_pred[2] ? tce : lce;
        src = (rx_pred[2] || rx_pred[1]) ? pser[nidx] : line_in;
        if (lce) fac_exp = line_in;
        if (rce && sc < HN) begin
          smp[sc] = src;
          sc++;
        end
      end
    end
  end

  task automatic run(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic set_modes(input bit f, input bit e, input bit c, input bit b, input bit l);
    @(negedge clk);
    #3;
    fac_lb_en = f; equ_lb_en = e; cru_lb_en = c; cru_byp_en = b; loop_time_en = l;
  endtask

  task automatic t_reset;
    run(3);
    #3;
    chk(tx_ser_out == 1'b0, "R12", "reset tx_ser_out", int'(tx_ser_out), 0);
    chk(rx_par == '0, "R12", "reset rx_par", int'(rx_par), 0);
    chk(rx_par_vld == 1'b0, "R12", "reset rx_par_vld", int'(rx_par_vld), 0);
    @(negedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic t_default;
    tx_tag = "R1"; rx_tag = "R12";
    chk_tx = 1'b1; chk_rx = 1'b1;
    run(16);
    #3;
    load_cnt = 0;
    run(64);
    #3;
    chk(load_cnt == 64 / DW, "R2", "strobes in 64 cycles", load_cnt, 64 / DW);
  endtask

  task automatic t_fac;
    tx_tag = "R3"; rx_tag = "R4";
    set_modes(1, 0, 0, 0, 0);
    run(80);
  endtask

  task automatic t_equ;
    tx_tag = "R6"; rx_tag = "R5";
    set_modes(0, 1, 0, 0, 0);
    run(80);
  endtask

  task automatic t_both;
    tx_tag = "R10"; rx_tag = "R10";
    set_modes(1, 1, 0, 0, 0);
    run(80);
    set_modes(0, 0, 0, 0, 0);
    run(24);
  endtask

  task automatic t_cru;
    tx_tag = "R1"; rx_tag = "R7";
    rec_alt = 1'b1;
    set_modes(0, 0, 1, 0, 0);
    run(96);
    set_modes(0, 0, 0, 0, 0);
    run(40);
    rec_alt = 1'b0;
    run(24);
  endtask

  task automatic t_byp;
    tx_tag = "R1"; rx_tag = "R8";
    ext_alt = 1'b1;
    set_modes(0, 0, 0, 1, 0);
    run(100);
    set_modes(0, 0, 0, 0, 0);
    run(40);
    ext_alt = 1'b0;
    run(24);
  endtask

  task automatic t_bound;
    tx_tag = "R11"; rx_tag = "R11";
    do begin
      @(negedge clk);
      #3;
    end while (!tx_byte_strobe);
    run(3);
    #3;
    fac_lb_en = 1'b1;
    run(30);
    set_modes(0, 0, 0, 0, 0);
    run(13);
    #3;
    equ_lb_en = 1'b1;
    run(40);
    #3;
    equ_lb_en = 1'b0;
    run(40);
  endtask

  task automatic t_loop;
    tx_tag = "R9"; rx_tag = "R12";
    set_modes(0, 0, 0, 0, 1);
    run(16);
    v_tx_local = 1'b0;
    run(64);
    chk_tx = 1'b0;
    set_modes(0, 0, 0, 0, 0);
    run(20);
  endtask

  task automatic t_freeze;
    logic held;
    @(negedge clk);
    #3;
    held = tx_ser_out;
    load_cnt = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      #3;
      chk(tx_byte_strobe == 1'b0, "R2", "strobe while frozen", int'(tx_byte_strobe), 0);
      chk(tx_ser_out == held, "R2", "tx held while frozen", int'(tx_ser_out), int'(held));
    end
    chk(load_cnt == 0, "R2", "loads while frozen", load_cnt, 0);
  endtask

  initial begin
    t_reset;
    t_default;
    t_fac;
    t_equ;
    t_both;
    t_cru;
    t_byp;
    t_bound;
    t_loop;
    t_freeze;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule